// File: doc/BRIEF.md
# Pointer-Addressed Temperature Sensor Register Bank

This block is the register file behind a two-wire serial temperature-sensor target. An upstream bus front end decodes each transaction into simple strobes: load the 8-bit pointer, write a data byte, or read a data byte. The block answers each accepted strobe with an acknowledge and returns read bytes. The pointer selects one of 256 sixteen-bit locations. Each location follows its own access rule: fixed identification words, four read-write setup and limit words, a temperature word loaded from a converter stub, and reserved space that reads as zero.

Each 16-bit word travels as two bytes, most significant byte first. A byte-index flag moves from high to low and clears on every pointer load. The pointer keeps its value between transactions, so the same word can be read again and again without reloading it. A temperature sample that arrives between the two bytes of a temperature read is dropped, so both bytes of one read come from the same sample.

A power-on reset request loads every default. The block then stays in reset until the filtered bus clock is seen high. The bus clock is first synchronised, then passed through a glitch filter. The filter ignores any level change that lasts fewer than a set number of system clocks (50 ns at the default setting).

Top module: `sensor_regbank`

## Requirements
- R1: A pointer strobe sets the pointer to `ptr_val` and the byte index to high. The pointer holds this value across any number of data reads and writes, until the next pointer strobe.
- R2: Each word moves high byte first. The first data byte read returns bits 15:8 and the second returns bits 7:0, after which the index goes back to high. A word write takes effect only when its second (low) byte arrives.
- R3: After reset the words read as: 0017h at 00h, 0000h at 01h–04h, 1131h at 06h, A200h at 07h, and 0000h at 08h–FFh (this includes 22h).
- R4: Locations 01h–04h are read-write. A full two-byte write is read back unchanged, and each of the four is stored separately.
- R5: Locations 00h, 05h, 06h and 07h are read-only. A write to one of them is acknowledged, and the word it holds does not change.
- R6: Locations 08h–FFh always read as 0000h, and writes to them have no effect.
- R7: A sample strobe loads `smp_val` into location 05h. This does not happen while the pointer is 05h and the byte index is low.
- R8: If a sample arrives between the high-byte read and the low-byte read of location 05h, the low byte still comes from the sample that supplied the high byte.
- R9: After a reset request, `in_por` stays high for as long as the filtered bus clock is low. It goes low on the clock after `scl_filt` rises.
- R10: `scl_filt` follows `scl_in` through a two-flop synchroniser. It changes only after the synchronised level has differed from it for FILT_CYCLES system clocks in a row, so shorter pulses are rejected.
- R11: `ack` is high in the cycle after any strobe accepted outside reset, and low otherwise. Strobes that arrive during reset are ignored. Read data appears on `rd_byte` in the same cycle as its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on reset request, active high |
| scl_in | input | 1 | Raw bus clock level |
| scl_filt | output | 1 | Bus clock after synchronising and filtering |
| in_por | output | 1 | High while the block is held in reset |
| ptr_stb | input | 1 | Pointer load strobe |
| ptr_val | input | 8 | New pointer value |
| wr_stb | input | 1 | Data byte write strobe |
| wr_byte | input | 8 | Data byte to write |
| rd_stb | input | 1 | Data byte read strobe |
| rd_byte | output | 8 | Read byte, valid together with ack |
| ack | output | 1 | Acknowledge for the previous cycle's strobe |
| smp_stb | input | 1 | Temperature sample strobe |
| smp_val | input | 16 | Temperature sample |

## Verification
The assertions assume the front end raises at most one of the three bus strobes in any cycle. They also assume no strobe is checked while the reset request is high. The bench drives each strobe for exactly one cycle on the falling clock edge, with idle cycles in between. It changes the raw bus clock only at falling edges and holds each level for a known number of cycles, so that the filter timing can be predicted.

// File: rtl/sensor_regbank.sv
module sensor_regbank #(
  parameter int FILT_CYCLES = 13,
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          por_req,
  input  logic          scl_in,
  output logic          scl_filt,
  output logic          in_por,
  input  logic          ptr_stb,
  input  logic [AW-1:0] ptr_val,
  input  logic          wr_stb,
  input  logic [7:0]    wr_byte,
  input  logic          rd_stb,
  output logic [7:0]    rd_byte,
  output logic          ack,
  input  logic          smp_stb,
  input  logic [DW-1:0] smp_val
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam int NRW = 4;
  localparam logic [DW-1:0] CAP_W = 16'h0017;
  localparam logic [DW-1:0] VEN_W = 16'h1131;
  localparam logic [DW-1:0] DEV_W = 16'hA200;

  logic          s1, s2;
  logic [CW-1:0] fcnt;
  logic [AW-1:0] ptr;
  logic          idx;
  logic [7:0]    hi_hold;
  logic [DW-1:0] rw_q [NRW];
  logic [DW-1:0] temp_q;
  logic [DW-1:0] word;

  wire       hit_rw = (ptr >= AW'(1)) && (ptr <= AW'(NRW));
  wire [1:0] rw_i   = 2'(ptr - AW'(1));
  wire       temp_lock = (ptr == AW'(5)) && idx;

  always_ff @(posedge clk) begin
    if (por_req) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      scl_filt <= 1'b0;
      fcnt <= '0;
    end else begin
      s1 <= scl_in;
      s2 <= s1;
      if (s2 != scl_filt) begin
        if (fcnt == CW'(FILT_CYCLES - 1)) begin
          scl_filt <= s2;
          fcnt <= '0;
        end else begin
          fcnt <= fcnt + CW'(1);
        end
      end else begin
        fcnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por_req) in_por <= 1'b1;
    else if (scl_filt) in_por <= 1'b0;
  end

  always_comb begin
    word = '0;
    if (hit_rw) word = rw_q[rw_i];
    else if (ptr == AW'(0)) word = CAP_W;
    else if (ptr == AW'(5)) word = temp_q;
    else if (ptr == AW'(6)) word = VEN_W;
    else if (ptr == AW'(7)) word = DEV_W;
  end

  always_ff @(posedge clk) begin
    if (in_por) begin
      ptr <= '0;
      idx <= 1'b0;
      hi_hold <= '0;
      ack <= 1'b0;
      rd_byte <= '0;
      for (int i = 0; i < NRW; i++) rw_q[i] <= '0;
    end else begin
      ack <= ptr_stb | wr_stb | rd_stb;
      if (ptr_stb) begin
        ptr <= ptr_val;
        idx <= 1'b0;
      end else if (wr_stb) begin
        if (!idx) hi_hold <= wr_byte;
        else if (hit_rw) rw_q[rw_i] <= {hi_hold, wr_byte};
        idx <= ~idx;
      end else if (rd_stb) begin
        rd_byte <= idx ? word[7:0] : word[15:8];
        idx <= ~idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (smp_stb && !temp_lock) temp_q <= smp_val;
  end
endmodule

module sensor_regbank_chk (
  input logic       clk,
  input logic       por_req,
  input logic       in_por,
  input logic       s2,
  input logic       scl_filt,
  input logic       ptr_stb,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       ack,
  input logic [7:0] ptr,
  input logic       idx,
  input logic [7:0] rd_byte,
  input logic [15:0] temp_q
);
  wire only_rd = rd_stb && !ptr_stb && !wr_stb && !in_por;

  // R11
  ack_follows_chk: assert property (@(posedge clk) disable iff (por_req || in_por)
    (ptr_stb || wr_stb || rd_stb) |=> ack);
  // R11
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (por_req || in_por)
    !(ptr_stb || wr_stb || rd_stb) |=> !ack);
  // R9
  hold_por_chk: assert property (@(posedge clk) disable iff (por_req)
    (in_por && !scl_filt) |=> in_por);
  // R10
  filt_moves_chk: assert property (@(posedge clk) disable iff (por_req)
    (scl_filt != $past(scl_filt)) |-> ($past(s2) == scl_filt));
  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (por_req || in_por)
    (only_rd && ptr >= 8'h08) |=> rd_byte == 8'h00);
  // R8
  temp_low_chk: assert property (@(posedge clk) disable iff (por_req || in_por)
    (only_rd && ptr == 8'h05 && idx) |=> rd_byte == $past(temp_q[7:0]));
endmodule

bind sensor_regbank sensor_regbank_chk u_chk (
  .clk(clk), .por_req(por_req), .in_por(in_por), .s2(s2), .scl_filt(scl_filt),
  .ptr_stb(ptr_stb), .wr_stb(wr_stb), .rd_stb(rd_stb), .ack(ack),
  .ptr(ptr), .idx(idx), .rd_byte(rd_byte), .temp_q(temp_q)
);

// File: tb/tb_sensor_regbank.sv
module tb_sensor_regbank;
  localparam int FILT = 13;
  logic clk = 0, por_req = 1, scl_in = 0;
  logic ptr_stb = 0, wr_stb = 0, rd_stb = 0, smp_stb = 0;
  logic [7:0] ptr_val = 0, wr_byte = 0;
  logic [15:0] smp_val = 0;
  logic scl_filt, in_por, ack;
  logic [7:0] rd_byte;
  int tests = 0, fails = 0;
  logic [7:0] b;
  logic [15:0] w;

  sensor_regbank #(.FILT_CYCLES(FILT)) dut (.*);

  always #2 clk = ~clk;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    @(negedge clk); ptr_stb = 1; ptr_val = p;
    @(negedge clk); ptr_stb = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_stb = 1; wr_byte = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0; d = rd_byte;
    if (ack !== 1'b1) chk("R11", {15'd0, ack}, 16'd1);
  endtask

  task automatic rd_word(input logic [7:0] p, output logic [15:0] v);
    logic [7:0] h, l;
    set_ptr(p); rd(h); rd(l); v = {h, l};
  endtask

  task automatic sample(input logic [15:0] v);
    @(negedge clk); smp_stb = 1; smp_val = v;
    @(negedge clk); smp_stb = 0;
  endtask

  function automatic logic [15:0] dflt(input int a);
    case (a)
      0: return 16'h0017;
      6: return 16'h1131;
      7: return 16'hA200;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] pat(input int a);
    return {8'(a) ^ 8'h5A, ~8'(a)};
  endfunction

  initial begin
    idle(4);
    por_req = 0;
    idle(40);
    chk("R9 held while clock low", {15'd0, in_por}, 16'd1);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    chk("R11 no ack in reset", {15'd0, ack}, 16'd0);
    scl_in = 1;
    idle(FILT - 2);
    chk("R9 still in reset before window", {15'd0, in_por}, 16'd1);
    idle(8);
    chk("R10 filtered clock high", {15'd0, scl_filt}, 16'd1);
    chk("R9 reset released", {15'd0, in_por}, 16'd0);
    idle(1);
    chk("R11 idle ack low", {15'd0, ack}, 16'd0);

    for (int n = 1; n < FILT; n += 4) begin
      logic seen_low;
      seen_low = 0;
      scl_in = 0; idle(n); scl_in = 1;
      repeat (FILT + 6) begin
        @(negedge clk);
        if (!scl_filt) seen_low = 1;
      end
      chk("R10 short pulse rejected", {15'd0, seen_low}, 16'd0);
    end
    scl_in = 0; idle(FILT + 4);
    chk("R10 long low accepted", {15'd0, scl_filt}, 16'd0);
    chk("R9 no re-entry without request", {15'd0, in_por}, 16'd0);
    scl_in = 1; idle(FILT + 4);
    chk("R10 long high accepted", {15'd0, scl_filt}, 16'd1);

    sample(16'h0C4D);
    for (int a = 0; a < 256; a++) begin
      rd_word(8'(a), w);
      chk(a == 5 ? "R7 sample loaded" : (a >= 8 ? "R6 reserved reads zero" : "R3 default"),
          w, a == 5 ? 16'h0C4D : dflt(a));
    end

    for (int a = 0; a < 256; a++) begin
      set_ptr(8'(a)); wr(pat(a)[15:8]); wr(pat(a)[7:0]);
    end
    for (int a = 0; a < 256; a++) begin
      rd_word(8'(a), w);
      if (a >= 1 && a <= 4) chk("R4 read-write readback", w, pat(a));
      else if (a < 8) chk("R5 read-only unchanged", w, a == 5 ? 16'h0C4D : dflt(a));
      else chk("R6 reserved ignores write", w, 16'h0000);
    end

    set_ptr(8'h02); wr(8'hAB);
    rd_word(8'h02, w);
    chk("R2 half write no effect", w, pat(2));
    set_ptr(8'h03); wr(8'h12); wr(8'h34);
    rd(b); chk("R2 high byte first", {8'd0, b}, 16'h0012);
    rd(b); chk("R2 low byte second", {8'd0, b}, 16'h0034);
    rd(b); chk("R1 pointer kept, index wraps", {8'd0, b}, 16'h0012);
    rd(b); chk("R1 repeated read low", {8'd0, b}, 16'h0034);
    rd_word(8'h04, w);
    chk("R4 neighbour independent", w, pat(4));

    set_ptr(8'h05);
    sample(16'h1A2B);
    rd(b); chk("R8 high from first sample", {8'd0, b}, 16'h001A);
    sample(16'h3C4D);
    rd(b); chk("R8 low from same sample", {8'd0, b}, 16'h002B);
    sample(16'h5E6F);
    rd(b); chk("R7 new sample after read", {8'd0, b}, 16'h005E);
    rd(b); chk("R7 new sample low", {8'd0, b}, 16'h006F);

    @(negedge clk); por_req = 1; scl_in = 0;
    idle(3); por_req = 0; idle(5);
    chk("R9 reset re-entered", {15'd0, in_por}, 16'd1);
    scl_in = 1; idle(FILT + 6);
    rd_word(8'h03, w);
    chk("R3 defaults reloaded", w, 16'h0000);
    rd_word(8'h00, w);
    chk("R3 capability after reload", w, 16'h0017);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule